// File: doc/BRIEF.md
# SPI Master with Bit-Truncated Final Byte

This block is an SPI master running in clock mode 0 (SCLK idles low, data launched on the falling edge and captured on the rising edge) with a single active-low chip select. A host issues one command word that gives a byte count, a tail drop count and a transfer direction. The block then moves that many bytes, most significant bit first. The final byte of the transfer is shortened by the tail drop count, so any bit length from 1 to `8*count` can be clocked. Write, read and full-duplex transfers are supported.

Transmit bytes come in on a valid/ready stream. Received bytes leave as single-cycle `rx_valid` pulses. A received truncated byte is returned left-aligned: the bits that were never clocked read as zero. The SCLK half period is set by the parameter `HALF_DIV`, counted in system clock cycles.

The controller is a five-state machine:
- `ST_IDLE`: chip select released; `cmd_ready` is high.
- `ST_FETCH`: the next byte is loaded. In write and duplex modes this state waits for `tx_valid`.
- `ST_LOW`: SCLK low phase.
- `ST_HIGH`: SCLK high phase.
- `ST_TAIL`: chip-select hold time after the last falling edge.

The transitions are:
- accept (IDLE→FETCH): a legal command arrives.
- load (FETCH→LOW): a byte is loaded.
- rise (LOW→HIGH): the phase timer expires.
- fall-next-bit (HIGH→LOW): more bits remain in the byte.
- fall-next-byte (HIGH→FETCH): the byte is done and more bytes remain.
- fall-last (HIGH→TAIL): the last bit of the last byte is done.
- release (TAIL→IDLE): the hold time ends.

A rejected command leaves the block in IDLE and pulses `cmd_err`.

Top module: `spi_tail_master`

## Requirements
- R1: SCLK idles low. MOSI is stable for the whole time SCLK is high and changes only at a falling edge or while SCLK is low. MISO is sampled at the rising edge.
- R2: SCLK is high only while `cs_n` is low. Every high phase lasts exactly `HALF_DIV` cycles and every low phase inside a frame lasts at least `HALF_DIV` cycles. `cs_n` falls at least `HALF_DIV` cycles before the first rising edge and rises exactly `HALF_DIV` cycles after the last falling edge.
- R3: Bits go out most significant bit first. A frame has exactly `8*cmd_len - cmd_drop` rising edges.
- R4: The drop count (0 to 7) shortens only the final byte and removes its least significant bits. All earlier bytes are shifted in full.
- R5: Each received byte appears on `rx_data` left-aligned, and its unclocked low bits are 0. With MOSI looped to MISO, the last byte reads back as the sent byte AND `8'hFF << drop`, and full bytes read back unchanged.
- R6: A command with `cmd_drop` of 8 or more, with `cmd_len` of 0, or with `cmd_dir` of 2'b00 is rejected. `cmd_err` pulses high for one cycle, starting the cycle after the command, and no frame starts.
- R7: In read mode, exactly `cmd_len` `rx_valid` pulses occur, including the truncated last byte, and MOSI holds its previous level for the whole frame.
- R8: In write mode, exactly `cmd_len` transmit bytes are consumed and no `rx_valid` pulse occurs. Transmit stalls only stretch the SCLK low time.
- R9: `busy` rises in the cycle after a command is accepted and stays high until `cs_n` is released. `busy` always equals the inverse of `cs_n`, and `cmd_ready` is high only while idle.
- R10: `cmd_dir` is encoded as 2'b01 for write, 2'b10 for read and 2'b11 for full duplex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_len | input | LEN_W | Byte count, 1 or more |
| cmd_drop | input | 4 | Bits to remove from the final byte |
| cmd_dir | input | 2 | Transfer direction (R10) |
| cmd_err | output | 1 | One-cycle pulse on rejected command |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Block wants a transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte, left-aligned |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The embedded properties assume the following about the inputs:
- `cmd_valid` is only honoured while idle.
- `tx_valid` and `tx_data` are steady for the edge that consumes them.
- MISO can change at any time except the sampling edge.

The bench meets these assumptions in three ways:
- All inputs are driven on the falling system-clock edge.
- A byte is offered only while its index is below the byte count.
- The read-side MISO pattern changes only mid-way through an SCLK high phase.

With loopback enabled, MISO is MOSI itself, which is held over each rising edge by R1.

// File: rtl/spi_tail_pkg.sv
package spi_tail_pkg;

    localparam int BYTE_W     = 8;
    localparam int DROP_W     = 4;
    localparam int DROP_LIMIT = 8;

    typedef enum logic [1:0] {
        XFER_NONE   = 2'b00,
        XFER_WRITE  = 2'b01,
        XFER_READ   = 2'b10,
        XFER_DUPLEX = 2'b11
    } xfer_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } st_e;

endpackage

// File: rtl/spi_tail_phase.sv
module spi_tail_phase #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2: the phase counter never passes the half-period limit
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/spi_tail_shift.sv
module spi_tail_shift
    import spi_tail_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              tx_en,
    input  logic              advance,
    input  logic              sample,
    input  logic              miso,
    input  logic [2:0]        pad,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic              mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            tx_sh <= load_byte;
            rx_sh <= '0;
            if (tx_en)
                mosi_q <= load_byte[BYTE_W-1];
        end else begin
            if (advance) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                if (tx_en)
                    mosi_q <= tx_sh[BYTE_W-2];
            end
            if (sample)
                rx_sh <= {rx_sh[BYTE_W-2:0], miso};
        end
    end

    assign mosi    = mosi_q;
    assign rx_byte = rx_sh << pad;

    // R1: a byte load never coincides with a clock edge action
    p_load_alone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(advance || sample));

endmodule

// File: rtl/spi_tail_ctrl.sv
module spi_tail_ctrl
    import spi_tail_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DROP_W-1:0] cmd_drop,
    input  logic [1:0]        cmd_dir,
    input  logic              tx_valid,
    input  logic              tick,
    output logic              cmd_ready,
    output logic              cmd_err,
    output logic              tx_ready,
    output logic              load,
    output logic              tx_en,
    output logic              advance,
    output logic              sample,
    output logic              capture,
    output logic [2:0]        pad,
    output logic              run,
    output logic              sclk,
    output logic              cs_n,
    output logic              busy
);
    st_e               state, state_nx;
    logic [LEN_W-1:0]  byte_left;
    logic [3:0]        bit_left;
    logic [DROP_W-1:0] drop_q;
    xfer_e             dir_q;
    logic [2:0]        pad_q;
    logic              sclk_q, cs_n_q, err_q;
    logic              cmd_ok, fetch_go, last_bit, last_byte, hi_end;

    assign cmd_ok    = (cmd_dir != XFER_NONE) &&
                       (cmd_drop < DROP_W'(DROP_LIMIT)) &&
                       (cmd_len != '0);
    assign fetch_go  = (state == ST_FETCH) && (!dir_q[0] || tx_valid);
    assign last_bit  = (bit_left == 4'd1);
    assign last_byte = (byte_left == LEN_W'(1));
    assign hi_end    = (state == ST_HIGH) && tick;

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid && cmd_ok) state_nx = ST_FETCH;
            ST_FETCH: if (fetch_go)            state_nx = ST_LOW;
            ST_LOW:   if (tick)                state_nx = ST_HIGH;
            ST_HIGH:  if (tick)                state_nx = !last_bit ? ST_LOW :
                                                          (last_byte ? ST_TAIL : ST_FETCH);
            ST_TAIL:  if (tick)                state_nx = ST_IDLE;
            default:                           state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_left <= '0;
            bit_left  <= '0;
            drop_q    <= '0;
            dir_q     <= XFER_NONE;
            pad_q     <= '0;
        end else begin
            if (state == ST_IDLE && cmd_valid && cmd_ok) begin
                byte_left <= cmd_len;
                drop_q    <= cmd_drop;
                dir_q     <= xfer_e'(cmd_dir);
            end
            if (fetch_go) begin
                bit_left <= last_byte ? (4'd8 - drop_q) : 4'd8;
                pad_q    <= last_byte ? drop_q[2:0] : 3'd0;
            end else if (hi_end) begin
                bit_left <= bit_left - 4'd1;
                if (last_bit)
                    byte_left <= byte_left - LEN_W'(1);
            end
        end
    end

    // registered outputs, taken from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
            err_q  <= 1'b0;
        end else begin
            sclk_q <= (state_nx == ST_HIGH);
            cs_n_q <= (state_nx == ST_IDLE);
            err_q  <= (state == ST_IDLE) && cmd_valid && !cmd_ok;
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign tx_ready  = (state == ST_FETCH) && dir_q[0];
    assign load      = fetch_go;
    assign tx_en     = dir_q[0];
    assign sample    = (state == ST_LOW) && tick;
    assign advance   = hi_end && !last_bit;
    assign capture   = hi_end && last_bit && dir_q[1];
    assign pad       = pad_q;
    assign run       = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);
    assign sclk      = sclk_q;
    assign cs_n      = cs_n_q;
    assign cmd_err   = err_q;

    // R4: a frame in progress always holds a legal drop count
    p_drop_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (drop_q < DROP_W'(DROP_LIMIT)));
    // R3: a high phase always has at least one bit to finish
    p_bits_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> (bit_left != 4'd0));
    // R2: the serial clock toggles only inside a selected frame
    p_sclk_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q |-> !cs_n_q);
    // R6: a rejection pulse leaves the machine idle
    p_reject_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (state == ST_IDLE));

endmodule

// File: rtl/spi_tail_master.sv
module spi_tail_master
    import spi_tail_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int LEN_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DROP_W-1:0] cmd_drop,
    input  logic [1:0]        cmd_dir,
    output logic              cmd_err,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              busy,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    logic              tick, run, load, tx_en, advance, sample, capture;
    logic [2:0]        pad;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_valid_q;
    logic [BYTE_W-1:0] rx_data_q;

    spi_tail_phase #(.HALF_DIV(HALF_DIV)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_tail_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_len   (cmd_len),
        .cmd_drop  (cmd_drop),
        .cmd_dir   (cmd_dir),
        .tx_valid  (tx_valid),
        .tick      (tick),
        .cmd_ready (cmd_ready),
        .cmd_err   (cmd_err),
        .tx_ready  (tx_ready),
        .load      (load),
        .tx_en     (tx_en),
        .advance   (advance),
        .sample    (sample),
        .capture   (capture),
        .pad       (pad),
        .run       (run),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .busy      (busy)
    );

    spi_tail_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (tx_data),
        .tx_en     (tx_en),
        .advance   (advance),
        .sample    (sample),
        .miso      (miso),
        .pad       (pad),
        .mosi      (mosi),
        .rx_byte   (rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= capture;
            if (capture)
                rx_data_q <= rx_byte;
        end
    end

    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;

    // R1: MOSI holds through every SCLK high phase
    p_mosi_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R7: received bytes are reported only inside a frame
    p_rx_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);
    // R9: the busy flag tracks chip select
    p_busy_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !cs_n);

endmodule

// File: tb/spi_tail_master_test.sv
module spi_tail_master_test;

    localparam int HALF  = 3;
    localparam int LEN_W = 8;
    localparam int WDOG  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [7:0] cmd_len = '0;
    logic [3:0] cmd_drop = '0;
    logic [1:0] cmd_dir = '0;
    logic       cmd_err;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = '0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       busy, sclk, cs_n, mosi, miso;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [7:0] tx_src [0:15];
    logic [7:0] rd_src [0:15];
    bit         loop_sel = 1'b1;
    int         rise_cnt = 0;
    logic [6:0] rise_idx;

    assign rise_idx = rise_cnt[6:0];
    assign miso = loop_sel ? mosi : rd_src[rise_idx[6:3]][3'd7 - rise_idx[2:0]];

    always #10 clk = ~clk;

    spi_tail_master #(.HALF_DIV(HALF), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
        .cmd_drop(cmd_drop), .cmd_dir(cmd_dir), .cmd_err(cmd_err),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle protocol model
    bit         bit_q[$];
    logic [7:0] rx_q[$];
    logic       p_sclk = 1'b0, p_cs_n = 1'b1, p_mosi = 1'b0;
    int         low_run = 0, high_run = 0, mosi_flips = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == !cs_n, "R9 busy vs cs_n", busy, !cs_n);
            if (sclk) check(!cs_n, "R2 sclk outside frame", cs_n, 0);
            if (sclk && p_sclk) check(mosi == p_mosi, "R1 mosi moved while sclk high", mosi, p_mosi);
            if (!cs_n && !p_cs_n && mosi != p_mosi) mosi_flips++;
            if (!cs_n && p_cs_n) rise_cnt = 0;
            if (sclk && !p_sclk) begin
                check(low_run >= HALF, "R2 low phase length", low_run, HALF);
                bit_q.push_back(mosi);
                rise_cnt++;
            end
            if (!sclk && p_sclk) check(high_run == HALF, "R2 high phase length", high_run, HALF);
            if (cs_n && !p_cs_n) check(low_run == HALF, "R2 cs hold after last fall", low_run, HALF);
            high_run = sclk ? high_run + 1 : 0;
            low_run  = (!cs_n && !sclk) ? low_run + 1 : 0;
            if (rx_valid) rx_q.push_back(rx_data);
            p_sclk = sclk; p_cs_n = cs_n; p_mosi = mosi;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
            summary();
        end
    end

    task automatic xfer(input int len, input int drop, input logic [1:0] dir,
                        input bit stall, input bit lp, output int taken);
        int idx, c;
        bit pend, started;
        bit_q.delete(); rx_q.delete(); mosi_flips = 0; loop_sel = lp;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_len = 8'(len); cmd_drop = 4'(drop); cmd_dir = dir;
        idx = 0; pend = 0; started = 0; c = 0;
        while (1) begin
            @(negedge clk);
            cmd_valid = 1'b0; c++;
            if (pend) begin idx++; pend = 0; end
            if (dir[0] && idx < len) begin
                tx_valid = stall ? (c % 3 == 0) : 1'b1;
                tx_data  = tx_src[idx];
            end else tx_valid = 1'b0;
            if (tx_valid && tx_ready) pend = 1;
            if (busy) started = 1;
            if ((started && !busy) || c > 20000) break;
        end
        tx_valid = 1'b0;
        taken = idx;
        repeat (2) @(negedge clk);
    endtask

    task automatic verify(input int len, input int drop, input logic [1:0] dir, input int taken);
        int nbits, b, k, good;
        logic [7:0] exp;
        nbits = 8 * len - drop;
        check(bit_q.size() == nbits, "R3 rising edge count", bit_q.size(), nbits);
        if (dir[0]) begin
            check(taken == len, "R8 tx bytes consumed", taken, len);
            good = 1;
            for (int i = 0; i < nbits && i < bit_q.size(); i++) begin
                b = i / 8; k = 7 - (i % 8);
                if (bit_q[i] != tx_src[b][k]) good = 0;
            end
            check(good == 1, "R4 MSB-first bits with tail drop", good, 1);
        end
        if (!dir[1]) check(rx_q.size() == 0, "R8 no rx on write", rx_q.size(), 0);
        else begin
            check(rx_q.size() == len, "R7 rx byte count", rx_q.size(), len);
            for (int i = 0; i < len && i < rx_q.size(); i++) begin
                exp = dir[0] ? tx_src[i] : rd_src[i];
                if (i == len - 1) exp = exp & (8'hFF << drop);
                check(rx_q[i] == exp, "R5 rx byte value", rx_q[i], exp);
            end
        end
        if (dir == 2'b10) check(mosi_flips == 0, "R7 mosi held in read", mosi_flips, 0);
    endtask

    task automatic reject(input int len, input int drop, input logic [1:0] dir, input string tag);
        int seen;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_len = 8'(len); cmd_drop = 4'(drop); cmd_dir = dir;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_err == 1'b1, tag, cmd_err, 1);
        seen = 0;
        @(negedge clk);
        check(cmd_err == 1'b0, "R6 error is one cycle", cmd_err, 0);
        repeat (10) begin
            @(negedge clk);
            if (busy || !cs_n) seen++;
        end
        check(seen == 0, "R6 no frame after reject", seen, 0);
    endtask

    initial begin
        int taken;
        for (int i = 0; i < 16; i++) begin
            tx_src[i] = 8'(8'h3C + 8'(i * 37));
            rd_src[i] = 8'(8'hC9 ^ 8'(i * 29));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R9, R1)
        check(cs_n == 1'b1, "R9 reset cs_n", cs_n, 1);
        check(sclk == 1'b0, "R1 reset sclk idle low", sclk, 0);
        check(busy == 1'b0, "R9 reset busy", busy, 0);
        check(cmd_ready == 1'b1, "R9 reset cmd_ready", cmd_ready, 1);
        check(rx_valid == 1'b0 && tx_ready == 1'b0, "R8 reset strobes", rx_valid, 0);

        // R10 write, one full byte
        tx_src[0] = 8'hA5;
        xfer(1, 0, 2'b01, 0, 1, taken); verify(1, 0, 2'b01, taken);
        // R4 write, three bytes, tail cut by 3, stalled source
        xfer(3, 3, 2'b01, 1, 1, taken); verify(3, 3, 2'b01, taken);
        // R5 duplex loopback FF, CF with every drop count
        tx_src[0] = 8'hFF; tx_src[1] = 8'hCF;
        for (int d = 0; d < 8; d++) begin
            xfer(2, d, 2'b11, d[0], 1, taken); verify(2, d, 2'b11, taken);
        end
        // R7 read-only, truncated last byte
        xfer(3, 5, 2'b10, 0, 0, taken); verify(3, 5, 2'b10, taken);
        // R7 read-only single byte, maximum drop
        xfer(1, 7, 2'b10, 0, 0, taken); verify(1, 7, 2'b10, taken);
        // R3 longer duplex with stall
        for (int i = 0; i < 6; i++) tx_src[i] = 8'(8'h11 * (i + 3));
        xfer(6, 2, 2'b11, 1, 1, taken); verify(6, 2, 2'b11, taken);
        // R6 illegal commands
        reject(2, 8, 2'b11, "R6 drop of 8 rejected");
        reject(1, 15, 2'b01, "R6 drop of 15 rejected");
        reject(0, 0, 2'b01, "R6 zero length rejected");
        reject(2, 0, 2'b00, "R6 empty direction rejected");
        // still operational afterwards (R9)
        check(cmd_ready == 1'b1, "R9 ready after rejects", cmd_ready, 1);
        xfer(1, 1, 2'b11, 0, 1, taken); verify(1, 1, 2'b11, taken);
        summary();
    end

endmodule